// File: doc/BRIEF.md
# Ethernet Receive Frame Acceptance Filter

This block sits on the receive byte stream of an Ethernet MAC and decides, for every frame, whether the frame is kept or discarded. It takes the destination address from the first six bytes of the frame, most significant byte first. It compares that address against a single station address and against the all-ones broadcast address, applies the broadcast-reject and promiscuous settings, and issues one registered decision per frame. If the frame also carries the broadcast address, the decision is marked.

At the same time the block counts the bytes of the frame with a saturating counter. When the count passes a software-programmable limit, it raises a long-frame flag for the receive buffer descriptor and fires a one-cycle babble interrupt. Frames that start while the transmitter is active can be blocked as a whole, which suits half-duplex links. A small register port holds the control bits and the length limit.

Top module: `rx_accept_filter`

## Requirements
- R1: With bc_reject (control bit 0) set and promisc (control bit 1) clear, a frame whose destination address is 0xFFFF_FFFF_FFFF is dropped. With both bits clear, such a frame is accepted and dec_mark is 1.
- R2: With bc_reject and promisc both set, a broadcast frame is accepted and dec_mark is 1.
- R3: With promisc set, every frame of six or more bytes is accepted, whatever its destination address.
- R4: With promisc clear, a non-broadcast frame is accepted only if its destination address equals station_addr. A frame of fewer than six bytes is dropped, and its decision appears in the cycle after its end-of-frame byte.
- R5: The destination address is bytes 1 to 6 of the frame, first byte most significant. dec_valid is a one-cycle pulse in the cycle after the sixth byte. dec_accept and dec_mark are 0 whenever dec_valid is 0.
- R6: long_flag rises in the cycle after the byte that makes the frame's byte count exceed max length. babble_irq pulses for one cycle at the same time, at most once per frame.
- R7: The max length register (address 1, bits 10:0) resets to 1518 and is writable.
- R8: With drt (control bit 2) set, a frame whose start byte arrives while tx_active is 1 produces no dec_valid, long_flag or babble_irq. With drt clear, tx_active has no effect.
- R9: The control register is at address 0. Unused bits of both registers read as 0, and unmapped addresses read as 0.
- R10: The byte count saturates at 65535, so a frame of any length produces exactly one decision.
- R11: long_flag holds until the next start-of-frame byte clears it. Bytes that arrive outside a frame (after end-of-frame, before the next start) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | A received byte is present on rx_data |
| rx_data | input | 8 | Received byte |
| rx_sof | input | 1 | The current byte is the first byte of a frame |
| rx_eof | input | 1 | The current byte is the last byte of a frame |
| tx_active | input | 1 | The transmitter is sending |
| station_addr | input | 48 | This station's individual address |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 max length) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from reg_addr |
| dec_valid | output | 1 | Decision pulse, once per unblocked frame |
| dec_accept | output | 1 | Frame accepted (qualified by dec_valid) |
| dec_mark | output | 1 | Accepted frame was broadcast (qualified by dec_valid) |
| long_flag | output | 1 | Current or last frame exceeded max length |
| babble_irq | output | 1 | One-cycle long-frame interrupt |

## Verification
The address decision and the long-frame detection are both evaluated on the same byte beat, so they can land in the same cycle. The bench provokes this by programming the length limit to 5 and sending frames of eight bytes. The sixth byte then both completes the address and pushes the count past the limit, and the reference model expects dec_valid, long_flag and babble_irq all to rise in the single following cycle. A one-byte frame with the limit at 0 brings start-of-frame clearing and long-frame setting onto one beat in the same way.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int DA_BYTES = 6;
  localparam int DA_W     = 8 * DA_BYTES;

  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_MAXLEN = 2'd1;

  localparam int CTRL_W = 3;

  // packed order sets the bit positions: bit0 bc_reject, bit1 promisc, bit2 drt
  typedef struct packed {
    logic drt;
    logic promisc;
    logic bc_reject;
  } rxf_ctrl_t;
endpackage

// File: rtl/rxf_regs.sv
module rxf_regs
  import rxf_pkg::*;
#(
  parameter int              REG_AW  = 2,
  parameter int              REG_DW  = 16,
  parameter int              LEN_W   = 11,
  parameter logic [LEN_W-1:0] LEN_RST = 11'd1518
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [REG_DW-1:0] wdata,
  output logic [REG_DW-1:0] rdata,
  output rxf_ctrl_t         ctrl,
  output logic [LEN_W-1:0]  max_len
);
  rxf_ctrl_t        ctrl_q, ctrl_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic             unused_wdata_hi;

  assign unused_wdata_hi = ^wdata[REG_DW-1:LEN_W];

  always_comb begin
    ctrl_d = ctrl_q;
    len_d  = len_q;
    if (wr_en && addr == REG_AW'(ADDR_CTRL))   ctrl_d = rxf_ctrl_t'(wdata[CTRL_W-1:0]);
    if (wr_en && addr == REG_AW'(ADDR_MAXLEN)) len_d  = wdata[LEN_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      len_q  <= LEN_RST;
    end else begin
      ctrl_q <= ctrl_d;
      len_q  <= len_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      REG_AW'(ADDR_CTRL):   rdata[CTRL_W-1:0] = ctrl_q;
      REG_AW'(ADDR_MAXLEN): rdata[LEN_W-1:0]  = len_q;
      default:              rdata = '0;
    endcase
  end

  assign ctrl    = ctrl_q;
  assign max_len = len_q;

  // R7: the length limit leaving reset is the default value
  p_len_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (max_len == LEN_RST));

  // R9: upper control bits never read back as ones
  p_ctrl_unused_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == REG_AW'(ADDR_CTRL)) |-> (rdata[REG_DW-1:CTRL_W] == '0));
endmodule

// File: rtl/rxf_byte_counter.sv
module rxf_byte_counter #(
  parameter int CNT_W = 16,
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             live,
  input  logic             sof,
  input  logic             eval,
  input  logic [LEN_W-1:0] max_len,
  output logic [CNT_W-1:0] cnt_next,
  output logic             long_flag,
  output logic             babble_irq
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d, limit;
  logic             long_q, long_d, bab_q, bab_d;

  always_comb begin
    limit = {{(CNT_W-LEN_W){1'b0}}, max_len};
    if (sof)                   cnt_next = CNT_W'(1);
    else if (cnt_q == CNT_TOP) cnt_next = cnt_q;
    else                       cnt_next = cnt_q + CNT_W'(1);
    cnt_d = live ? cnt_next : cnt_q;

    long_d = (live && sof) ? 1'b0 : long_q;
    bab_d  = 1'b0;
    if (eval && (cnt_next > limit) && !long_d) begin
      long_d = 1'b1;
      bab_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      long_q <= 1'b0;
      bab_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      long_q <= long_d;
      bab_q  <= bab_d;
    end
  end

  assign long_flag  = long_q;
  assign babble_irq = bab_q;

  // R10: a full counter stays full until the next frame start
  p_cnt_saturate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_TOP && live && !sof) |=> (cnt_q == CNT_TOP));

  // R6: the interrupt only comes with a raised long flag
  p_babble_with_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    babble_irq |-> long_flag);

  // R6: within one frame the flag stays up and no further interrupt follows
  p_babble_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (long_flag && !(live && sof)) |=> (long_flag && !babble_irq));
endmodule

// File: rtl/rxf_da_decide.sv
module rxf_da_decide
  import rxf_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             live,
  input  logic             sof,
  input  logic             eof,
  input  logic             eval,
  input  logic [7:0]       data,
  input  logic [CNT_W-1:0] cnt_next,
  input  logic [DA_W-1:0]  station_addr,
  input  rxf_ctrl_t        ctrl,
  output logic             dec_valid,
  output logic             dec_accept,
  output logic             dec_mark
);
  localparam logic [CNT_W-1:0] CNT_DA = CNT_W'(DA_BYTES);

  logic [DA_W-1:0] da_q, da_d;
  logic            val_d, acc_d, mark_d, val_q, acc_q, mark_q;
  logic            is_bcast;

  always_comb begin
    da_d = da_q;
    if (live) begin
      if (sof)                    da_d = {{(DA_W-8){1'b0}}, data};
      else if (cnt_next <= CNT_DA) da_d = {da_q[DA_W-9:0], data};
    end
    is_bcast = &da_d;

    val_d  = 1'b0;
    acc_d  = 1'b0;
    mark_d = 1'b0;
    if (eval && cnt_next == CNT_DA) begin
      val_d = 1'b1;
      if (ctrl.promisc)  acc_d = 1'b1;
      else if (is_bcast) acc_d = !ctrl.bc_reject;
      else               acc_d = (da_d == station_addr);
      mark_d = is_bcast && acc_d;
    end else if (eval && eof && cnt_next < CNT_DA) begin
      val_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      da_q   <= '0;
      val_q  <= 1'b0;
      acc_q  <= 1'b0;
      mark_q <= 1'b0;
    end else begin
      da_q   <= da_d;
      val_q  <= val_d;
      acc_q  <= acc_d;
      mark_q <= mark_d;
    end
  end

  assign dec_valid  = val_q;
  assign dec_accept = acc_q;
  assign dec_mark   = mark_q;

  // R2: a marked decision is always an acceptance
  p_mark_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dec_mark |-> (dec_accept && dec_valid));

  // R3: promiscuous mode accepts at the address-complete byte
  p_promisc_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && cnt_next == CNT_DA && ctrl.promisc) |=> (dec_valid && dec_accept));

  // R4: a frame ending before its address completes is dropped
  p_short_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && eof && cnt_next < CNT_DA) |=> (dec_valid && !dec_accept));
endmodule

// File: rtl/rx_accept_filter.sv
module rx_accept_filter
  import rxf_pkg::*;
#(
  parameter int               CNT_W   = 16,
  parameter int               LEN_W   = 11,
  parameter logic [LEN_W-1:0] LEN_RST = 11'd1518,
  parameter int               REG_AW  = 2,
  parameter int               REG_DW  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic              tx_active,
  input  logic [47:0]       station_addr,
  input  logic              reg_wr_en,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  output logic              dec_valid,
  output logic              dec_accept,
  output logic              dec_mark,
  output logic              long_flag,
  output logic              babble_irq
);
  rxf_ctrl_t        ctrl;
  logic [LEN_W-1:0] max_len;
  logic [CNT_W-1:0] cnt_next;
  logic             in_q, in_d, blk_q, blk_d;
  logic             sof_beat, live, blk_now, eval;

  rxf_regs #(
    .REG_AW(REG_AW), .REG_DW(REG_DW), .LEN_W(LEN_W), .LEN_RST(LEN_RST)
  ) i_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .ctrl(ctrl), .max_len(max_len)
  );

  always_comb begin
    sof_beat = rx_valid && rx_sof;
    live     = rx_valid && (rx_sof || in_q);
    blk_now  = sof_beat ? (ctrl.drt && tx_active) : blk_q;
    eval     = live && !blk_now;
    in_d     = live ? !rx_eof : in_q;
    blk_d    = live ? blk_now : blk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q  <= 1'b0;
      blk_q <= 1'b0;
    end else begin
      in_q  <= in_d;
      blk_q <= blk_d;
    end
  end

  rxf_byte_counter #(.CNT_W(CNT_W), .LEN_W(LEN_W)) i_count (
    .clk(clk), .rst_n(rst_n), .live(live), .sof(sof_beat), .eval(eval),
    .max_len(max_len), .cnt_next(cnt_next), .long_flag(long_flag),
    .babble_irq(babble_irq)
  );

  rxf_da_decide #(.CNT_W(CNT_W)) i_decide (
    .clk(clk), .rst_n(rst_n), .live(live), .sof(sof_beat), .eof(rx_eof),
    .eval(eval), .data(rx_data), .cnt_next(cnt_next),
    .station_addr(station_addr), .ctrl(ctrl), .dec_valid(dec_valid),
    .dec_accept(dec_accept), .dec_mark(dec_mark)
  );

  // R8: a blocked frame stays silent after its start byte
  p_blocked_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !rx_sof && blk_q) |=> (!dec_valid && !babble_irq));

  // R11: bytes outside a frame raise no decision
  p_idle_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_sof && !in_q) |=> !dec_valid);
endmodule

// File: tb/test_rx_accept_filter.sv
module test_rx_accept_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, tx_active = 1'b0;
  logic [7:0]  rx_data = 8'h00;
  logic [47:0] station_addr = 48'h02_1A_2B_3C_4D_5E;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_addr = 2'd1;
  logic [15:0] reg_wdata = 16'h0000;
  logic [15:0] reg_rdata;
  logic        dec_valid, dec_accept, dec_mark, long_flag, babble_irq;

  int    total = 0;
  int    bad = 0;
  int    cycles = 0;
  string cur_req = "R7";

  rx_accept_filter i_rx_accept_filter (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_sof(rx_sof), .rx_eof(rx_eof), .tx_active(tx_active),
    .station_addr(station_addr), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dec_valid(dec_valid),
    .dec_accept(dec_accept), .dec_mark(dec_mark), .long_flag(long_flag),
    .babble_irq(babble_irq)
  );

  always #5 clk = ~clk;

  // behavioural reference model
  int         m_cnt;
  bit         m_in, m_blk;
  bit [2:0]   m_ctrl;
  bit [10:0]  m_max;
  byte        m_q[$];
  bit         e_val, e_acc, e_mark, e_long, e_bab;
  logic [15:0] e_rdata;

  task automatic chk(input string sig, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got %h expected %h at cycle %0d", cur_req, sig, got, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_cnt = 0; m_in = 0; m_blk = 0; m_ctrl = 0; m_max = 11'd1518;
      m_q.delete();
      e_val = 0; e_acc = 0; e_mark = 0; e_long = 0; e_bab = 0;
    end else begin
      e_val = 0; e_acc = 0; e_mark = 0; e_bab = 0;
      if (rx_valid && (rx_sof || m_in)) begin
        if (rx_sof) begin
          m_in = 1; m_blk = m_ctrl[2] && tx_active; m_cnt = 1;
          m_q.delete(); m_q.push_back(rx_data); e_long = 0;
        end else begin
          if (m_cnt < 65535) m_cnt = m_cnt + 1;
          if (m_q.size() < 6) m_q.push_back(rx_data);
        end
        if (!m_blk) begin
          if (m_cnt == 6) begin
            logic [47:0] da;
            bit bc;
            da = 0;
            foreach (m_q[k]) da = {da[39:0], m_q[k]};
            bc = (da == 48'hFFFF_FFFF_FFFF);
            e_val = 1;
            if (m_ctrl[1])  e_acc = 1;
            else if (bc)    e_acc = !m_ctrl[0];
            else            e_acc = (da == station_addr);
            e_mark = bc && e_acc;
          end else if (rx_eof && m_cnt < 6) begin
            e_val = 1;
          end
          if (m_cnt > int'(m_max) && !e_long) begin
            e_long = 1; e_bab = 1;
          end
        end
        if (rx_eof) m_in = 0;
      end
      if (reg_wr_en && reg_addr == 2'd0) m_ctrl = reg_wdata[2:0];
      if (reg_wr_en && reg_addr == 2'd1) m_max = reg_wdata[10:0];
    end
    e_rdata = (reg_addr == 2'd0) ? {13'd0, m_ctrl} :
              (reg_addr == 2'd1) ? {5'd0, m_max} : 16'h0000;
    #3;
    if (rst_n) begin
      chk("dec_valid",  {15'd0, dec_valid},  {15'd0, e_val});
      chk("dec_accept", {15'd0, dec_accept}, {15'd0, e_acc});
      chk("dec_mark",   {15'd0, dec_mark},   {15'd0, e_mark});
      chk("long_flag",  {15'd0, long_flag},  {15'd0, e_long});
      chk("babble_irq", {15'd0, babble_irq}, {15'd0, e_bab});
      chk("reg_rdata",  reg_rdata, e_rdata);
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 0; rx_sof = 0; rx_eof = 0; reg_wr_en = 0;
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    rx_valid = 0; rx_sof = 0; rx_eof = 0;
    reg_wr_en = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 0;
  endtask

  // frame of len bytes: address bytes first, most significant first; optional one-cycle gap
  task automatic frame(input logic [47:0] da, input int len, input int gap_at);
    for (int i = 0; i < len; i++) begin
      if (i == gap_at) begin
        @(negedge clk);
        rx_valid = 0; rx_sof = 0; rx_eof = 0;
      end
      @(negedge clk);
      rx_valid = 1;
      rx_sof   = (i == 0);
      rx_eof   = (i == len - 1);
      rx_data  = (i < 6) ? da[47 - 8*i -: 8] : 8'(i);
    end
    @(negedge clk);
    rx_valid = 0; rx_sof = 0; rx_eof = 0;
    idle(2);
  endtask

  localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] OTHER = 48'h02_1A_2B_3C_4D_5F;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(2);
    cur_req = "R7"; reg_addr = 2'd1; idle(1);        // reset value of the length limit
    cur_req = "R4"; frame(station_addr, 12, -1);
    frame(OTHER, 12, -1);
    cur_req = "R5"; frame(station_addr, 9, 3);        // gap inside the address bytes
    frame(48'h03_00_00_00_00_00, 10, -1);
    cur_req = "R1"; frame(BCAST, 10, -1);            // reject clear: accepted, marked
    wr(2'd0, 16'h0001); frame(BCAST, 10, -1);
    cur_req = "R2"; wr(2'd0, 16'h0003); frame(BCAST, 10, -1);
    cur_req = "R3"; wr(2'd0, 16'h0002); frame(OTHER, 10, -1);
    frame(station_addr, 7, -1);
    cur_req = "R4"; wr(2'd0, 16'h0000); frame(station_addr, 4, -1);
    frame(station_addr, 1, -1);
    cur_req = "R9"; reg_addr = 2'd0; wr(2'd0, 16'hFFF8); idle(1);
    wr(2'd0, 16'hFFFF); idle(1);
    reg_addr = 2'd2; idle(1); reg_addr = 2'd3; idle(1);
    wr(2'd1, 16'hFFFF); reg_addr = 2'd1; idle(1);
    wr(2'd0, 16'h0000);
    cur_req = "R6"; wr(2'd1, 16'd20); frame(station_addr, 20, -1);
    frame(station_addr, 21, -1);
    frame(OTHER, 30, 10);
    wr(2'd1, 16'd5); frame(station_addr, 8, -1);      // decision and babble together
    cur_req = "R11"; wr(2'd1, 16'd0); frame(station_addr, 1, -1);
    wr(2'd1, 16'd1518); frame(station_addr, 10, -1);   // flag clears at start
    @(negedge clk); rx_valid = 1; rx_data = 8'hAA; rx_sof = 0; rx_eof = 0;
    @(negedge clk); rx_valid = 1; rx_eof = 1;
    idle(3);
    cur_req = "R8"; wr(2'd0, 16'h0004); wr(2'd1, 16'd10); tx_active = 1;
    frame(station_addr, 15, -1);
    frame(station_addr, 3, -1);
    tx_active = 0; frame(station_addr, 15, -1);
    wr(2'd0, 16'h0000); tx_active = 1; frame(station_addr, 15, -1);
    tx_active = 0;
    cur_req = "R10"; wr(2'd1, 16'd1518); frame(station_addr, 66000, -1);
    idle(4);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1900000;
    bad++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule